// File: doc/BRIEF.md
# Quadratic secant interpolator for the logarithmic addition function

This block evaluates the function used when two numbers held as base-two logarithms are added: sb(z) = log2(1 + 2^z) for z ≤ 0. The caller supplies the magnitude w = -z as an unsigned fixed-point code. The upper bits of the code pick a table interval of width Δ, and the lower bits give the offset δ inside that interval. The result is a fixed-point fraction with a valid strobe, one clock after the request.

The estimate has three parts. A secant line runs through the function values at both ends of the interval, and its slope comes from two adjacent entries of one table that is read at two addresses at once. A second-order correction, proportional to the curvature times δ(Δ-δ), is then subtracted. The curvature is not multiplied in. Its base-two logarithm, taken from the same table, is added to a small offset-indexed table of log2(δ(Δ-δ)) terms. The sum goes back to the linear domain with a shift-and-mantissa approximation of 2^x. The single table holds nΔ + 2F(-nΔ), which is the negated log of the second derivative up to a constant. The function value itself is recovered from that entry by a subtraction and a halving, so the only fixed-point multiplier is the one that forms the linear term.

Top module: `sb_quad_interp`

## Requirements
- R1: `in_code` bits [11:7] are the interval index n and bits [6:0] are the offset d, with w = in_code / 512 and Δ = 1/4. `out_value` / 16384 approximates log2(1 + 2^-w), and code 0 yields exactly 16384.
- R2: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low.
- R3: While `rst_n` is low, and right after it is released, `out_valid` is 0 and `out_value` is 0.
- R4: When d = 0, the output equals the rounded table value log2(1 + 2^-nΔ) within one output LSB, because the linear term and the correction are both zero.
- R5: For every input code, the absolute error of the output against the exact function is at most 2^-10.
- R6: Over all codes, the largest error is at most one quarter of the largest error of a tangent-line estimate taken at the left end of the same interval.
- R7: The correction is never added. The output never exceeds the exact secant-line value by more than one LSB.
- R8: A cycle with `in_valid` low leaves `out_value` unchanged, whatever `in_code` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_code | input | 12 | Magnitude of z: interval index above, offset below |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_value | output | 15 | Approximation of sb, 14 fraction bits |

## Verification
Offset zero is the first corner. A design that fails to clamp the correction there would pull every tabulated point low by one Mitchell term, and the check against the rounded table value catches that. The last interval (index 31) reads the table entry past the address range. An off-by-one in the second read port would bend the secant at the top of the range and break the error bound. The bench sweeps every code, so a wrong sign on the correction, or a correction that is added instead of subtracted, shows up either as an output above the secant line or as an error no better than the tangent estimate. Holding `in_valid` low while `in_code` changes shows whether the output register loads when it should not.

// File: rtl/sb_quad_interp.sv
module sb_quad_interp #(
  parameter int AB = 5,
  parameter int OB = 7,
  parameter int IB = 3,
  parameter int FB = 14,
  parameter int CB = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [AB+OB-1:0] in_code,
  output logic            out_valid,
  output logic [FB:0]     out_value
);
  localparam int  IW   = AB + OB;
  localparam int  FA   = AB - IB;
  localparam int  S    = FB + 2;
  localparam int  TW   = S + 5;
  localparam int  EW   = S + 7;
  localparam int  TD   = (1 << AB) + 1;
  localparam int  CD   = 1 << CB;
  localparam int  PW   = TW + OB + 1;
  localparam int  OW   = FB + 1;
  localparam int  RB   = S - FB;
  localparam int  SHW  = $clog2(S + 1);
  localparam int  MAXV = 1 << FB;
  localparam real DELTA = 1.0 / (1 << FA);
  localparam real SCALE = 2.0 ** S;

  function automatic logic signed [TW-1:0] t_entry(int i);
    real w, f;
    w = i * DELTA;
    f = $ln(1.0 + $pow(2.0, -w)) / $ln(2.0);
    return TW'($rtoi($floor((w + 2.0 * f) * SCALE + 0.5)));
  endfunction

  function automatic logic signed [EW-1:0] c_entry(int j);
    real dl, v;
    dl = (j + 0.5) * DELTA / (1 << CB);
    v  = ($ln($ln(2.0)) + $ln(dl * (DELTA - dl))) / $ln(2.0) - 1.0;
    return EW'($rtoi($floor(v * SCALE + 0.5)));
  endfunction

  logic signed [TW-1:0] t_rom [TD];
  logic signed [EW-1:0] c_rom [CD];

  for (genvar i = 0; i < TD; i++) begin : g_trom
    localparam logic signed [TW-1:0] V = t_entry(i);
    assign t_rom[i] = V;
  end
  for (genvar j = 0; j < CD; j++) begin : g_crom
    localparam logic signed [EW-1:0] V = c_entry(j);
    assign c_rom[j] = V;
  end

  logic [OB-1:0] d;
  logic [AB:0]   a0, a1;
  assign d  = in_code[OB-1:0];
  assign a0 = {1'b0, in_code[IW-1:OB]};
  assign a1 = a0 + 1'b1;

  logic signed [TW-1:0] t0, t1, f0, f1;
  assign t0 = t_rom[a0];
  assign t1 = t_rom[a1];
  assign f0 = (t0 - TW'({a0, {(S-FA){1'b0}}})) >>> 1;
  assign f1 = (t1 - TW'({a1, {(S-FA){1'b0}}})) >>> 1;

  logic signed [PW-1:0] prod, lin;
  assign prod = (f1 - f0) * $signed({1'b0, d});
  assign lin  = prod >>> OB;

  logic signed [EW-1:0] e, ei;
  logic [S:0]     mant, corr;
  logic [SHW-1:0] sh;
  logic           kill;
  assign e    = c_rom[d[OB-1:OB-CB]] - EW'(t0);
  assign ei   = e >>> S;
  assign mant = {1'b1, e[S-1:0]};
  assign sh   = SHW'(-ei);
  assign kill = (d == '0) || (ei < -(FB + 1));
  assign corr = kill ? '0 : (mant >> sh);

  logic signed [PW-1:0] sum, rnd;
  logic [OW-1:0] res;
  assign sum = PW'(f0) + lin - $signed({{(PW-S-1){1'b0}}, corr});
  assign rnd = (sum + PW'(1 << (RB - 1))) >>> RB;
  assign res = (rnd < 0) ? '0 : (rnd > PW'(MAXV)) ? OW'(MAXV) : rnd[OW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_value <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_value <= res;
    end
  end

  assert_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_value));
  assert_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_value <= OW'(MAXV));
  assert_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && out_value == '0));
endmodule

// File: tb/sb_quad_interp_test.sv
module sb_quad_interp_test;
  localparam int  IW  = 12;
  localparam real LSB = 1.0 / 16384.0;
  localparam int  NV  = 8;
  localparam int  VEC [NV] = '{0, 1, 127, 128, 1023, 2048, 3968, 4095};

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [IW-1:0] in_code = '0;
  logic out_valid;
  logic [14:0] out_value;
  int checks = 0, fails = 0;

  sb_quad_interp uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_code(in_code), .out_valid(out_valid), .out_value(out_value));

  always #4 clk = ~clk;

  function automatic real sbf(real w);
    return $ln(1.0 + $pow(2.0, -w)) / $ln(2.0);
  endfunction
  function automatic real sbd(real w);
    real p;
    p = $pow(2.0, -w);
    return p / (1.0 + p);
  endfunction
  function automatic real absr(real x);
    return (x < 0.0) ? -x : x;
  endfunction

  task automatic check(bit ok, string tag, real act, real exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%f expected=%f", tag, act, exp);
    end
  endtask

  task automatic apply(int code);
    @(negedge clk);
    in_valid = 1'b1;
    in_code  = IW'(code);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog R2 actual=%f expected=%f", 0.0, 1.0);
    summary();
    $finish;
  end

  initial begin
    real w, tr, got, sec, tan_e, err, max_e, max_t;
    int n, d, v;
    max_e = 0.0;
    max_t = 0.0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R3 valid in reset", real'(out_valid), 0.0);
    check(out_value == '0, "R3 value in reset", real'(out_value), 0.0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && out_value == '0, "R3 after release", real'(out_value), 0.0);

    for (int k = 0; k < NV; k++) begin
      apply(VEC[k]);
      check(out_valid == 1'b1, "R2 vector strobe", real'(out_valid), 1.0);
      tr = sbf(VEC[k] / 512.0);
      got = out_value * LSB;
      check(absr(got - tr) <= 1.0 / 1024.0, "R5 vector error", got, tr);
      if (VEC[k] == 0) check(out_value == 15'd16384, "R1 code zero", real'(out_value), 16384.0);
      @(negedge clk);
      check(out_valid == 1'b0, "R2 idle strobe", real'(out_valid), 0.0);
    end

    for (int code = 0; code < 4096; code++) begin
      apply(code);
      n = code >> 7;
      d = code & 127;
      w = code / 512.0;
      tr = sbf(w);
      got = out_value * LSB;
      err = absr(got - tr);
      if (err > max_e) max_e = err;
      tan_e = absr(sbf(n * 0.25) - (d / 512.0) * sbd(n * 0.25) - tr);
      if (tan_e > max_t) max_t = tan_e;
      check(out_valid == 1'b1, "R2 sweep strobe", real'(out_valid), 1.0);
      check(err <= 1.0 / 1024.0, "R5 sweep error", got, tr);
      sec = sbf(n * 0.25) + (d / 128.0) * (sbf((n + 1) * 0.25) - sbf(n * 0.25));
      check(got <= sec + LSB, "R7 below secant", got, sec);
      if (d == 0)
        check(absr(out_value - $floor(tr / LSB + 0.5)) <= 1.0, "R4 tabulated point",
              real'(out_value), $floor(tr / LSB + 0.5));
    end
    check(max_e * 4.0 <= max_t, "R6 versus tangent", max_e, max_t / 4.0);

    apply(1000);
    v = out_value;
    @(negedge clk);
    in_code = IW'(3000);
    repeat (3) @(negedge clk);
    check(out_value == 15'(v), "R8 hold while idle", real'(out_value), real'(v));
    check(out_valid == 1'b0, "R2 idle after hold", real'(out_valid), 0.0);

    apply(5);
    rst_n = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0 && out_value == '0, "R3 mid-run reset", real'(out_value), 0.0);
    rst_n = 1'b1;
    apply(0);
    check(out_value == 15'd16384, "R1 after reset", real'(out_value), 16384.0);

    summary();
    $finish;
  end
endmodule